// File: doc/BRIEF.md
# Quadrature encoder position counter

This block turns the two phase signals and the index signal of an incremental shaft encoder into a 32-bit position count. It counts in four-times mode, so each edge of either phase moves the count by one, up or down depending on which phase leads. The count runs between zero and a programmable ceiling. Passing the ceiling going up wraps to zero, and passing zero going down reloads the ceiling. Each wrap raises its own interrupt status bit. A reversal of direction raises a third bit. An index pulse can preset the count to zero, but only when both phases sit at a selected pair of levels. That preset can be switched off.

Software drives the block through a simple 32-bit register bus. Writes land on the clock edge and reads are combinational. The live count is also driven on a port for neighbouring logic. The encoder pins pass through a two-flop synchroniser. Each pin then has an optional inversion, and the two phases can be exchanged, before decoding.

A run state machine gates the counting. It has three states: OFF (disabled), ARM (one settling cycle) and RUN (decoding). The transitions are:
- OFF to ARM when enable is seen set.
- ARM to RUN when enable is still set.
- Any state to OFF when enable is clear.

Only RUN steps the count, so edges seen during OFF or ARM are ignored.

Top module: `qdec_counter`

## Requirements
- R1: After reset the count is 0 and the interrupt status is 0. The interrupt mask at offset 0x24 reads 0x3F and irq is low. The control register at offset 0x00 reads 0x00008000, where bit 15 is a constant capture-empty flag.
- R2: With enable (control bit 0) set, take phase levels as {A,B}. The sequence 00→10→11→01→00 adds one per change, and the reverse subtracts one. The count is readable at offset 0x08 and on `pos`.
- R3: Counting up while the count equals the ceiling (offset 0x0C) gives 0 and sets interrupt status bit 2.
- R4: Counting down while the count is 0 loads the ceiling and sets interrupt status bit 1.
- R5: A change of both phases in one sample leaves the count unchanged and sets control bit 7. Writing 1 to control bit 7 clears it.
- R6: A step in the opposite direction to the previous step since the block entered RUN sets interrupt status bit 3. The first step after entering RUN never sets it.
- R7: A rising index edge presets the count to 0 only when two conditions hold. First, control bit 8 is 0. Second, the decoded {A,B} equals control bits {10,9}, with bit 10 giving the level of A.
- R8: Control bits 2, 3 and 4 invert phase A, phase B and index respectively. Control bit 5 exchanges the inverted phases before decoding.
- R9: While enable is 1, writes to the ceiling, the filter length (offset 0x04) and every control bit except 0 and 7 are ignored.
- R10: Interrupt status (offset 0x20) bits are cleared by writing 1. If a clear and a new event coincide, the event wins. irq is the OR of the status bits whose mask bit is 0.
- R11: Outside RUN the count holds whatever the pins do. After enable is set, the first counted step is judged against phase levels sampled before it.
- R12: A phase change at the pins reaches the count on the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high |
| enc_a | input | 1 | Encoder phase A pin |
| enc_b | input | 1 | Encoder phase B pin |
| enc_idx | input | 1 | Encoder index pin |
| pos | output | 32 | Live position count |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is an index preset. It needs a rising index edge to arrive while the synchronised and transformed phases equal the gating pattern, and that pattern itself depends on the inversion and swap settings. The stimulus parks the phases on the gating pattern for several cycles, then pulses the index. It repeats the pulse with a non-matching pattern and again with the preset disabled. A behavioural model in the bench reproduces the three-flop input delay and the run state timing. It checks `pos` and `irq` on every clock, so any preset, wrap or direction event in the wrong cycle is caught.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    localparam int unsigned ADDR_W = 6;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned STAT_W = 6;
    localparam int unsigned FILT_W = 21;

    localparam logic [ADDR_W-1:0] A_CTRL  = 6'h00;
    localparam logic [ADDR_W-1:0] A_FILT  = 6'h04;
    localparam logic [ADDR_W-1:0] A_COUNT = 6'h08;
    localparam logic [ADDR_W-1:0] A_CEIL  = 6'h0C;
    localparam logic [ADDR_W-1:0] A_ISTAT = 6'h20;
    localparam logic [ADDR_W-1:0] A_IMASK = 6'h24;

    localparam int unsigned B_EN    = 0;
    localparam int unsigned B_FLT   = 1;
    localparam int unsigned B_INVA  = 2;
    localparam int unsigned B_INVB  = 3;
    localparam int unsigned B_INVI  = 4;
    localparam int unsigned B_SWAP  = 5;
    localparam int unsigned B_MODE  = 6;
    localparam int unsigned B_PERR  = 7;
    localparam int unsigned B_NOPRE = 8;

    localparam int unsigned S_DN  = 1;
    localparam int unsigned S_UP  = 2;
    localparam int unsigned S_DIR = 3;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_ARM = 2'd1,
        ST_RUN = 2'd2
    } run_state_t;

    typedef struct packed {
        logic       inv_a;
        logic       inv_b;
        logic       inv_i;
        logic       swap;
        logic       no_preset;
        logic [1:0] gate;
    } dec_cfg_t;

    typedef struct packed {
        logic wrap_up;
        logic wrap_dn;
        logic turn;
        logic bad;
    } dec_evt_t;

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int unsigned N      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    logic [STAGES-1:0][N-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/qdec_core.sv
module qdec_core
    import qdec_pkg::*;
#(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  dec_cfg_t      cfg,
    input  logic [CW-1:0] ceil,
    input  logic          a_s,
    input  logic          b_s,
    input  logic          i_s,
    output logic [CW-1:0] count,
    output dec_evt_t      evt
);

    run_state_t state_q, state_d;

    logic [CW-1:0] count_q;
    logic [1:0]    ph_q;
    logic          idx_q;
    logic          dir_q, dir_ok_q;

    logic a_p, b_p, a_e, b_e, i_e;
    logic [1:0] cur;
    logic run, mv_up, mv_dn, mv_bad;
    logic step_up, step_dn, bad, preset;
    logic at_ceil, at_zero;

    function automatic logic [1:0] ahead(input logic [1:0] p);
        case (p)
            2'b00:   ahead = 2'b10;
            2'b10:   ahead = 2'b11;
            2'b11:   ahead = 2'b01;
            default: ahead = 2'b00;
        endcase
    endfunction

    // pin transform: inversion first, then optional exchange
    always_comb begin
        a_p = a_s ^ cfg.inv_a;
        b_p = b_s ^ cfg.inv_b;
        if (cfg.swap) begin
            a_e = b_p;
            b_e = a_p;
        end else begin
            a_e = a_p;
            b_e = b_p;
        end
        i_e = i_s ^ cfg.inv_i;
        cur = {a_e, b_e};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_OFF;
        unique case (state_q)
            ST_OFF:  state_d = en ? ST_ARM : ST_OFF;
            ST_ARM:  state_d = en ? ST_RUN : ST_OFF;
            ST_RUN:  state_d = en ? ST_RUN : ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // output decode
    always_comb begin
        run     = (state_q == ST_RUN) && en;
        mv_up   = (cur == ahead(ph_q));
        mv_dn   = (ph_q == ahead(cur));
        mv_bad  = (cur == ~ph_q);
        step_up = run && mv_up;
        step_dn = run && mv_dn;
        bad     = run && mv_bad;
        preset  = run && i_e && !idx_q && (cur == cfg.gate) && !cfg.no_preset;
        at_ceil = (count_q == ceil);
        at_zero = (count_q == '0);
        evt.wrap_up = step_up && !preset && at_ceil;
        evt.wrap_dn = step_dn && !preset && at_zero;
        evt.turn    = (step_up || step_dn) && dir_ok_q && (dir_q != step_up);
        evt.bad     = bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            ph_q     <= 2'b00;
            idx_q    <= 1'b0;
            dir_q    <= 1'b0;
            dir_ok_q <= 1'b0;
        end else begin
            ph_q  <= cur;
            idx_q <= i_e;
            if (preset)       count_q <= '0;
            else if (step_up) count_q <= at_ceil ? '0 : count_q + 1'b1;
            else if (step_dn) count_q <= at_zero ? ceil : count_q - 1'b1;
            if (state_q != ST_RUN) begin
                dir_ok_q <= 1'b0;
            end else if (step_up || step_dn) begin
                dir_ok_q <= 1'b1;
                dir_q    <= step_up;
            end
        end
    end

    assign count = count_q;

    // R2
    step_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn, bad}));

    // R3
    wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && !preset && count_q == ceil) |=> (count_q == '0));

    // R4
    wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && !preset && count_q == '0) |=> (count_q == $past(ceil)));

    // R5
    bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad && !preset) |=> $stable(count_q));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |=> $stable(count_q));

endmodule

// File: rtl/qdec_regs.sv
module qdec_regs
    import qdec_pkg::*;
#(
    parameter int unsigned CW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  dec_evt_t          evt,
    input  logic [CW-1:0]     count,
    output logic              en,
    output dec_cfg_t          cfg,
    output logic [CW-1:0]     ceil,
    output logic              irq
);

    localparam logic [STAT_W-1:0] MASK_ALL = {STAT_W{1'b1}};

    logic              en_q, flt_q, mode_q, perr_q;
    dec_cfg_t          cfg_q;
    logic [3:0]        cap_q;
    logic [FILT_W-1:0] filt_q;
    logic [CW-1:0]     ceil_q;
    logic [STAT_W-1:0] stat_q, mask_q, stat_set, stat_clr;
    logic              wr, wr_ctrl, perr_clr;

    always_comb begin
        wr       = bus_sel && bus_wr;
        wr_ctrl  = wr && (bus_addr == A_CTRL);
        perr_clr = wr_ctrl && bus_wdata[B_PERR];
        stat_clr = (wr && bus_addr == A_ISTAT) ? bus_wdata[STAT_W-1:0] : '0;
        stat_set = '0;
        stat_set[S_UP]  = evt.wrap_up;
        stat_set[S_DN]  = evt.wrap_dn;
        stat_set[S_DIR] = evt.turn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            flt_q  <= 1'b0;
            mode_q <= 1'b0;
            perr_q <= 1'b0;
            cfg_q  <= '0;
            cap_q  <= '0;
            filt_q <= '0;
            ceil_q <= '0;
            stat_q <= '0;
            mask_q <= MASK_ALL;
        end else begin
            perr_q <= (perr_q && !perr_clr) || evt.bad;
            stat_q <= (stat_q & ~stat_clr) | stat_set;
            if (wr_ctrl) begin
                en_q <= bus_wdata[B_EN];
                if (!en_q) begin
                    flt_q           <= bus_wdata[B_FLT];
                    cfg_q.inv_a     <= bus_wdata[B_INVA];
                    cfg_q.inv_b     <= bus_wdata[B_INVB];
                    cfg_q.inv_i     <= bus_wdata[B_INVI];
                    cfg_q.swap      <= bus_wdata[B_SWAP];
                    mode_q          <= bus_wdata[B_MODE];
                    cfg_q.no_preset <= bus_wdata[B_NOPRE];
                    cfg_q.gate      <= bus_wdata[10:9];
                    cap_q           <= bus_wdata[14:11];
                end
            end
            if (wr && bus_addr == A_FILT && !en_q) filt_q <= bus_wdata[FILT_W-1:0];
            if (wr && bus_addr == A_CEIL && !en_q) ceil_q <= bus_wdata[CW-1:0];
            if (wr && bus_addr == A_IMASK)         mask_q <= bus_wdata[STAT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                A_CTRL:  bus_rdata[15:0] = {1'b1, cap_q, cfg_q.gate, cfg_q.no_preset,
                                            perr_q, mode_q, cfg_q.swap, cfg_q.inv_i,
                                            cfg_q.inv_b, cfg_q.inv_a, flt_q, en_q};
                A_FILT:  bus_rdata[FILT_W-1:0] = filt_q;
                A_COUNT: bus_rdata[CW-1:0]     = count;
                A_CEIL:  bus_rdata[CW-1:0]     = ceil_q;
                A_ISTAT: bus_rdata[STAT_W-1:0] = stat_q;
                A_IMASK: bus_rdata[STAT_W-1:0] = mask_q;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign en   = en_q;
    assign cfg  = cfg_q;
    assign ceil = ceil_q;
    assign irq  = |(stat_q & ~mask_q);

    // R9
    ceil_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(ceil_q));

    // R9
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(cfg_q));

    // R10
    stat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
    import qdec_pkg::*;
#(
    parameter int unsigned CW        = 32,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              enc_idx,
    output logic [CW-1:0]     pos,
    output logic              irq
);

    logic [2:0]    pins_s;
    logic          en;
    dec_cfg_t      cfg;
    logic [CW-1:0] ceil;
    logic [CW-1:0] count;
    dec_evt_t      evt;

    qdec_sync #(.N(3), .STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({enc_a, enc_b, enc_idx}),
        .q     (pins_s)
    );

    qdec_core #(.CW(CW)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .cfg   (cfg),
        .ceil  (ceil),
        .a_s   (pins_s[2]),
        .b_s   (pins_s[1]),
        .i_s   (pins_s[0]),
        .count (count),
        .evt   (evt)
    );

    qdec_regs #(.CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt       (evt),
        .count     (count),
        .en        (en),
        .cfg       (cfg),
        .ceil      (ceil),
        .irq       (irq)
    );

    assign pos = count;

endmodule

// File: tb/qdec_counter_test.sv
module qdec_counter_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
    logic [31:0] pos;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    logic  mon_on = 1'b0;

    qdec_counter uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx), .pos(pos), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%08h exp=%08h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural model ----------------
    logic [31:0] m_cnt = '0, m_ceil = '0;
    logic [5:0]  m_stat = '0, m_mask = 6'h3F;
    logic        m_en = 0, m_inva = 0, m_invb = 0, m_invi = 0, m_swap = 0, m_nopre = 0, m_perr = 0;
    logic [1:0]  m_gate = '0, m_ph = '0;
    logic        m_ip = 0, m_dir = 0, m_dirv = 0;
    int          m_run = 0;
    logic [2:0]  r1 = '0, r2 = '0;

    function automatic logic [1:0] lead(input logic [1:0] p);
        case (p)
            2'b00:   return 2'b10;
            2'b10:   return 2'b11;
            2'b11:   return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic ap, bp, ie, on, up, dn, bad, pre, wr;
        logic [1:0]  cur;
        logic [5:0]  set, clr;
        logic [31:0] nc;
        if (!rst_n) begin
            m_cnt = '0; m_ceil = '0; m_stat = '0; m_mask = 6'h3F; m_en = 0;
            m_inva = 0; m_invb = 0; m_invi = 0; m_swap = 0; m_nopre = 0; m_perr = 0;
            m_gate = '0; m_ph = '0; m_ip = 0; m_dir = 0; m_dirv = 0; m_run = 0;
            r1 = '0; r2 = '0;
        end else begin
            ap  = r2[2] ^ m_inva;
            bp  = r2[1] ^ m_invb;
            cur = m_swap ? {bp, ap} : {ap, bp};
            ie  = r2[0] ^ m_invi;
            on  = m_en && (m_run >= 2);
            up  = on && (cur == lead(m_ph));
            dn  = on && (m_ph == lead(cur));
            bad = on && (cur == ~m_ph);
            pre = on && ie && !m_ip && (cur == m_gate) && !m_nopre;
            set = '0;
            nc  = m_cnt;
            if (pre) nc = '0;
            else if (up) begin
                if (m_cnt == m_ceil) begin nc = '0; set[2] = 1; end else nc = m_cnt + 1;
            end else if (dn) begin
                if (m_cnt == 0) begin nc = m_ceil; set[1] = 1; end else nc = m_cnt - 1;
            end
            if ((up || dn) && m_dirv && (m_dir != up)) set[3] = 1;
            if (!on) m_dirv = 0;
            else if (up || dn) begin m_dirv = 1; m_dir = up; end
            wr  = bus_sel && bus_wr;
            clr = (wr && bus_addr == 6'h20) ? bus_wdata[5:0] : 6'h00;
            m_stat = (m_stat & ~clr) | set;
            m_perr = (m_perr && !(wr && bus_addr == 6'h00 && bus_wdata[7])) || bad;
            if (m_en) m_run = (m_run < 3) ? m_run + 1 : 3; else m_run = 0;
            if (wr && bus_addr == 6'h0C && !m_en) m_ceil = bus_wdata;
            if (wr && bus_addr == 6'h24) m_mask = bus_wdata[5:0];
            if (wr && bus_addr == 6'h00) begin
                if (!m_en) begin
                    m_inva = bus_wdata[2]; m_invb = bus_wdata[3]; m_invi = bus_wdata[4];
                    m_swap = bus_wdata[5]; m_nopre = bus_wdata[8]; m_gate = bus_wdata[10:9];
                end
                m_en = bus_wdata[0];
            end
            m_cnt = nc;
            m_ph  = cur;
            m_ip  = ie;
            r2    = r1;
            r1    = {enc_a, enc_b, enc_idx};
        end
    end

    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            chk({cur_req, " pos"}, pos, m_cnt);
            chk({cur_req, " irq"}, {31'b0, irq}, {31'b0, |(m_stat & ~m_mask)});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bwrite(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bread(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic expect_reg(input string tag, input logic [5:0] a, input logic [31:0] e);
        logic [31:0] v;
        bread(a, v);
        chk(tag, v, e);
    endtask

    task automatic pins(input logic a, input logic b);
        @(negedge clk);
        enc_a = a; enc_b = b;
        repeat (4) @(negedge clk);
    endtask

    task automatic fwd();
        logic [1:0] n;
        n = lead({enc_a, enc_b});
        pins(n[1], n[0]);
    endtask

    task automatic rev();
        logic [1:0] n;
        case ({enc_a, enc_b})
            2'b10:   n = 2'b00;
            2'b11:   n = 2'b10;
            2'b01:   n = 2'b11;
            default: n = 2'b01;
        endcase
        pins(n[1], n[0]);
    endtask

    task automatic idx_pulse();
        @(negedge clk); enc_idx = 1;
        repeat (4) @(negedge clk);
        enc_idx = 0;
        repeat (4) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL run-timeout act=hung exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- test sequence ----------------
    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        mon_on = 1;
        @(negedge clk);

        cur_req = "R1";
        chk("R1 pos", pos, 32'd0);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        expect_reg("R1 ctrl", 6'h00, 32'h0000_8000);
        expect_reg("R1 mask", 6'h24, 32'h0000_003F);
        expect_reg("R1 stat", 6'h20, 32'h0);

        cur_req = "R2";
        bwrite(6'h0C, 32'd5);
        bwrite(6'h00, 32'h1);
        repeat (4) @(negedge clk);
        repeat (4) fwd();
        expect_reg("R2 count up", 6'h08, 32'd4);

        cur_req = "R3";
        fwd(); fwd();
        chk("R3 wrap to zero", pos, 32'd0);
        expect_reg("R3 stat up", 6'h20, 32'h04);

        cur_req = "R10";
        chk("R10 masked irq", {31'b0, irq}, 32'd0);
        bwrite(6'h24, 32'h3B);
        chk("R10 irq unmasked", {31'b0, irq}, 32'd1);
        bwrite(6'h20, 32'h04);
        chk("R10 irq after clear", {31'b0, irq}, 32'd0);

        cur_req = "R4";
        rev();
        chk("R4 down reload", pos, 32'd5);
        cur_req = "R6";
        expect_reg("R6 R4 stat dir+dn", 6'h20, 32'h0A);
        rev();
        expect_reg("R6 no repeat", 6'h20, 32'h0A);
        bwrite(6'h20, 32'h3F);
        rev();
        chk("R2 count down", pos, 32'd3);

        cur_req = "R5";
        pins(~enc_a, ~enc_b);
        chk("R5 illegal hold", pos, 32'd3);
        expect_reg("R5 perr set", 6'h00, 32'h0000_8081);
        bwrite(6'h00, 32'h81);
        expect_reg("R5 perr clear", 6'h00, 32'h0000_8001);

        cur_req = "R9";
        bwrite(6'h0C, 32'd9);
        expect_reg("R9 ceil locked", 6'h0C, 32'd5);
        bwrite(6'h00, 32'h21);
        expect_reg("R9 ctrl locked", 6'h00, 32'h0000_8001);
        bwrite(6'h04, 32'h7);
        expect_reg("R9 filt locked", 6'h04, 32'h0);

        cur_req = "R7";
        bwrite(6'h00, 32'h0);
        bwrite(6'h00, 32'h600);
        bwrite(6'h00, 32'h601);
        pins(1, 1);
        repeat (4) @(negedge clk);
        v = pos;
        chk("R7 precondition nonzero", {31'b0, v != 0}, 32'd1);
        idx_pulse();
        chk("R7 preset on match", pos, 32'd0);
        fwd();
        idx_pulse();
        chk("R7 no preset on mismatch", pos, 32'd1);
        bwrite(6'h00, 32'h0);
        bwrite(6'h00, 32'h701);
        repeat (4) @(negedge clk);
        fwd(); fwd(); fwd();
        chk("R7 back on gate", pos, 32'd4);
        idx_pulse();
        chk("R7 preset disabled", pos, 32'd4);

        cur_req = "R8";
        bwrite(6'h00, 32'h0);
        bwrite(6'h00, 32'h21);
        repeat (4) @(negedge clk);
        fwd();
        chk("R8 swap reverses", pos, 32'd3);
        bwrite(6'h00, 32'h0);
        bwrite(6'h00, 32'h05);
        repeat (4) @(negedge clk);
        fwd();
        chk("R8 invert A reverses", pos, 32'd2);

        cur_req = "R11";
        bwrite(6'h00, 32'h0);
        fwd(); fwd(); rev(); fwd();
        chk("R11 hold while off", pos, 32'd2);
        bwrite(6'h00, 32'h1);
        repeat (4) @(negedge clk);
        chk("R11 no count on arm", pos, 32'd2);

        cur_req = "R12";
        begin
            logic [1:0] n;
            n = lead({enc_a, enc_b});
            @(negedge clk);
            enc_a = n[1]; enc_b = n[0];
            @(negedge clk);
            @(negedge clk);
            chk("R12 not after two edges", pos, 32'd2);
            @(negedge clk);
            chk("R12 after third edge", pos, 32'd3);
        end
        repeat (4) @(negedge clk);

        mon_on = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule